// File: doc/BRIEF.md
# Tagged Geometric-History Branch Direction Predictor

This block predicts the direction of conditional branches. A base table of 2-bit counters is indexed by the low bits of the branch address. Beside it sit several partially tagged tables. Each one is indexed and tagged by a hash that combines the branch address, a global outcome history of its own length and a short path history. The lengths double from one table to the next. All tables are read in the same cycle. The hitting table with the longest history provides the prediction, and the base table serves when no tagged table hits.

The lookup port is purely combinational. It returns the predicted direction and the identity of the provider. It also returns the current global and path history registers, which the front end keeps as the metadata for that branch. When the branch resolves, the update port receives the address, the outcome and that saved metadata. From these the block recomputes the indices and tags, trains the provider, adjusts usefulness, and allocates an entry in a longer-history table after a misprediction. The global and path histories advance on every update. A squash input overwrites them with a value that the front end supplies.

Top module: `tage_predictor`

## Requirements
- R1: After reset every tagged entry is invalid with useful 0, every base counter holds 01, and both history registers are zero. Every lookup then predicts not-taken (0) with provider code 0.
- R2: The base table is indexed by pc[LOG_B-1:0] and predicts taken when its 2-bit counter is 2 or more. On update it counts up on taken and down on not-taken, saturating at 3 and 0, and is trained only when it was the provider (provider code 0).
- R3: Tagged table i (0-based) uses the newest MIN_HIST*2^i history bits, where history bit 0 is the newest outcome. fold(v,n,w) XORs bit b of the n-bit value v into result bit b mod w. The index is fold(pc,PC_W,LOG_T) ^ fold(hist,L,LOG_T) ^ path. The tag is fold(pc>>LOG_T,PC_W-LOG_T,TAG_W) ^ fold(hist,L,TAG_W).
- R4: Table i hits when its indexed entry is valid and its tag equals the computed tag. The provider is the highest-numbered hitting table, reported as code i+1, with 0 meaning the base table. A tagged provider predicts taken when its 3-bit two's-complement counter is 0 or more. The alternate prediction comes from the next lower hitting table, or from the base table if there is none.
- R5: Lookup outputs the current global history and path registers. An update applies R3 and R4 to the supplied pc and history snapshot against the current table contents.
- R6: A tagged provider's counter moves toward the outcome, saturating at -4 and +3. The base table stays unchanged during that update.
- R7: A tagged provider's useful counter (2 bits) is incremented, saturating at 3, when the provider was right and the alternate wrong. It is decremented, saturating at 0, when the provider was wrong and the alternate right.
- R8: On a misprediction, the lowest-numbered table above the provider whose indexed entry has useful 0 receives a new entry: valid, the computed tag, useful 0, and counter 0 when the outcome was taken or -1 when it was not.
- R9: On a misprediction where no table above the provider has useful 0 at its indexed entry, nothing is allocated. The useful counters of all those entries are decremented instead.
- R10: Each update shifts the global history left and inserts the outcome at bit 0. It shifts the path register left and inserts up_pc[0]. Without an update or a squash, both registers hold.
- R11: A squash loads both history registers from sq_ghist and sq_path on the next edge. This takes precedence over the shift from an update in the same cycle, and that update still trains the tables.
- R12: When the provider predicted correctly, no entry is allocated and no useful counter outside the provider changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Branch address to predict |
| lk_pred | output | 1 | Predicted direction, 1 = taken |
| lk_prov | output | clog2(N_TAB+1) | Provider code: 0 = base, i+1 = tagged table i |
| lk_ghist | output | MIN_HIST*2^(N_TAB-1) | Global history to save as metadata |
| lk_path | output | PATH_W | Path history to save as metadata |
| up_valid | input | 1 | Resolved conditional branch present |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome |
| up_ghist | input | MIN_HIST*2^(N_TAB-1) | Global history saved at lookup |
| up_path | input | PATH_W | Path history saved at lookup |
| sq_valid | input | 1 | Restore the history registers |
| sq_ghist | input | MIN_HIST*2^(N_TAB-1) | Global history value to restore |
| sq_path | input | PATH_W | Path history value to restore |

## Verification
The bench builds the block with a 12-bit branch address and otherwise default parameters: four tagged tables of 32 entries with 4/8/16/32-bit histories, and a 64-entry base table. With so few index and tag bits, many addresses collide. This brings aliasing, replacement of live entries, useful-counter decay with no allocation, and counter saturation within a few thousand branches. A bench model built from the requirements predicts every lookup in biased, history-correlated and pseudo-random branch streams. Squashes are inserted mid-stream, including one in the same cycle as an update.

// File: rtl/tage_pkg.sv
`timescale 1ns/1ps
package tage_pkg;

    // 3-bit two's complement counter step, saturating at -4 and +3
    function automatic logic [2:0] ctr3_step(logic [2:0] c, logic taken);
        if (taken) return (c == 3'b011) ? c : c + 3'd1;
        return (c == 3'b100) ? c : c - 3'd1;
    endfunction

    // 2-bit unsigned counter step, saturating at 0 and 3
    function automatic logic [1:0] u2_step(logic [1:0] c, logic up);
        if (up) return (c == 2'd3) ? c : c + 2'd1;
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction

endpackage

// File: rtl/tage_hash.sv
`timescale 1ns/1ps
module tage_hash #(
    parameter int PC_W   = 16,
    parameter int LOG_T  = 5,
    parameter int TAG_W  = 6,
    parameter int PATH_W = 5,
    parameter int HLEN   = 4
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HLEN-1:0]   hist,
    input  logic [PATH_W-1:0] path,
    output logic [LOG_T-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    logic [LOG_T-1:0] fold_i;
    logic [TAG_W-1:0] fold_t;

    // XOR-fold address and history slice into index and tag widths
    always_comb begin
        fold_i = '0;
        fold_t = '0;
        for (int b = 0; b < PC_W; b++) fold_i[b % LOG_T] ^= pc[b];
        for (int b = LOG_T; b < PC_W; b++) fold_t[(b - LOG_T) % TAG_W] ^= pc[b];
        for (int b = 0; b < HLEN; b++) begin
            fold_i[b % LOG_T] ^= hist[b];
            fold_t[b % TAG_W] ^= hist[b];
        end
    end

    assign idx = fold_i ^ LOG_T'(path);
    assign tag = fold_t;
endmodule

// File: rtl/tage_index.sv
`timescale 1ns/1ps
module tage_index #(
    parameter int PC_W     = 16,
    parameter int N_TAB    = 4,
    parameter int LOG_T    = 5,
    parameter int TAG_W    = 6,
    parameter int MIN_HIST = 4,
    parameter int PATH_W   = 5,
    localparam int HIST_W  = MIN_HIST << (N_TAB - 1)
) (
    input  logic [PC_W-1:0]               pc,
    input  logic [HIST_W-1:0]             ghist,
    input  logic [PATH_W-1:0]             path,
    output logic [N_TAB-1:0][LOG_T-1:0]   idx,
    output logic [N_TAB-1:0][TAG_W-1:0]   tag
);
    // one hash per table, history length doubling per table
    for (genvar i = 0; i < N_TAB; i++) begin : g_tab
        tage_hash #(
            .PC_W(PC_W), .LOG_T(LOG_T), .TAG_W(TAG_W),
            .PATH_W(PATH_W), .HLEN(MIN_HIST << i)
        ) u_hash (
            .pc  (pc),
            .hist(ghist[(MIN_HIST << i)-1:0]),
            .path(path),
            .idx (idx[i]),
            .tag (tag[i])
        );
    end
endmodule

// File: rtl/tage_lookup.sv
`timescale 1ns/1ps
module tage_lookup #(
    parameter int N_TAB = 4,
    parameter int LOG_T = 5,
    parameter int TAG_W = 6,
    localparam int ENT  = 1 << LOG_T,
    localparam int PW   = $clog2(N_TAB + 1)
) (
    input  logic [N_TAB-1:0][LOG_T-1:0]            idx,
    input  logic [N_TAB-1:0][TAG_W-1:0]            tag,
    input  logic [N_TAB-1:0][ENT-1:0]              vld,
    input  logic [N_TAB-1:0][ENT-1:0][TAG_W-1:0]   tags,
    input  logic [N_TAB-1:0][ENT-1:0]              tpred,
    input  logic                                   bpred,
    output logic [N_TAB-1:0]                       hit,
    output logic [PW-1:0]                          prov,
    output logic                                   pred,
    output logic                                   alt
);
    always_comb begin
        for (int i = 0; i < N_TAB; i++)
            hit[i] = vld[i][idx[i]] && (tags[i][idx[i]] == tag[i]);
    end

    // ascending scan: last hit wins, previous winner becomes alternate
    always_comb begin
        prov = '0;
        pred = bpred;
        alt  = bpred;
        for (int i = 0; i < N_TAB; i++) begin
            if (hit[i]) begin
                alt  = pred;
                pred = tpred[i][idx[i]];
                prov = PW'(i + 1);
            end
        end
    end
endmodule

// File: rtl/tage_predictor.sv
`timescale 1ns/1ps
module tage_predictor #(
    parameter int PC_W     = 16,
    parameter int N_TAB    = 4,
    parameter int LOG_T    = 5,
    parameter int TAG_W    = 6,
    parameter int LOG_B    = 6,
    parameter int MIN_HIST = 4,
    parameter int PATH_W   = 5
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [PC_W-1:0]                        lk_pc,
    output logic                                   lk_pred,
    output logic [$clog2(N_TAB+1)-1:0]             lk_prov,
    output logic [(MIN_HIST<<(N_TAB-1))-1:0]       lk_ghist,
    output logic [PATH_W-1:0]                      lk_path,
    input  logic                                   up_valid,
    input  logic [PC_W-1:0]                        up_pc,
    input  logic                                   up_taken,
    input  logic [(MIN_HIST<<(N_TAB-1))-1:0]       up_ghist,
    input  logic [PATH_W-1:0]                      up_path,
    input  logic                                   sq_valid,
    input  logic [(MIN_HIST<<(N_TAB-1))-1:0]       sq_ghist,
    input  logic [PATH_W-1:0]                      sq_path
);
    import tage_pkg::*;

    localparam int ENT    = 1 << LOG_T;
    localparam int BIM_N  = 1 << LOG_B;
    localparam int HIST_W = MIN_HIST << (N_TAB - 1);
    localparam int PW     = $clog2(N_TAB + 1);

    typedef struct packed {
        logic [N_TAB-1:0][ENT-1:0]              vld;
        logic [N_TAB-1:0][ENT-1:0][TAG_W-1:0]   tag;
        logic [N_TAB-1:0][ENT-1:0][2:0]         ctr;
        logic [N_TAB-1:0][ENT-1:0][1:0]         usef;
        logic [BIM_N-1:0][1:0]                  bim;
        logic [HIST_W-1:0]                      ghist;
        logic [PATH_W-1:0]                      path;
    } state_t;

    state_t st_d, st_q;

    logic [N_TAB-1:0][ENT-1:0] tpred;
    logic [BIM_N-1:0]          bpred;

    always_comb begin
        for (int i = 0; i < N_TAB; i++)
            for (int e = 0; e < ENT; e++)
                tpred[i][e] = ~st_q.ctr[i][e][2];
        for (int b = 0; b < BIM_N; b++)
            bpred[b] = st_q.bim[b][1];
    end

    // lookup side: current histories
    logic [N_TAB-1:0][LOG_T-1:0] lk_idx;
    logic [N_TAB-1:0][TAG_W-1:0] lk_tag;
    logic [N_TAB-1:0]            lk_hit;
    logic                        lk_alt;

    tage_index #(.PC_W(PC_W), .N_TAB(N_TAB), .LOG_T(LOG_T), .TAG_W(TAG_W),
                 .MIN_HIST(MIN_HIST), .PATH_W(PATH_W)) u_lk_index (
        .pc(lk_pc), .ghist(st_q.ghist), .path(st_q.path),
        .idx(lk_idx), .tag(lk_tag)
    );

    tage_lookup #(.N_TAB(N_TAB), .LOG_T(LOG_T), .TAG_W(TAG_W)) u_lk_lookup (
        .idx(lk_idx), .tag(lk_tag), .vld(st_q.vld), .tags(st_q.tag),
        .tpred(tpred), .bpred(bpred[lk_pc[LOG_B-1:0]]),
        .hit(lk_hit), .prov(lk_prov), .pred(lk_pred), .alt(lk_alt)
    );

    assign lk_ghist = st_q.ghist;
    assign lk_path  = st_q.path;

    // update side: saved snapshot
    logic [N_TAB-1:0][LOG_T-1:0] up_idx;
    logic [N_TAB-1:0][TAG_W-1:0] up_tag;
    logic [N_TAB-1:0]            up_hit;
    logic [PW-1:0]               up_prov;
    logic                        up_pred;
    logic                        up_alt;

    tage_index #(.PC_W(PC_W), .N_TAB(N_TAB), .LOG_T(LOG_T), .TAG_W(TAG_W),
                 .MIN_HIST(MIN_HIST), .PATH_W(PATH_W)) u_up_index (
        .pc(up_pc), .ghist(up_ghist), .path(up_path),
        .idx(up_idx), .tag(up_tag)
    );

    tage_lookup #(.N_TAB(N_TAB), .LOG_T(LOG_T), .TAG_W(TAG_W)) u_up_lookup (
        .idx(up_idx), .tag(up_tag), .vld(st_q.vld), .tags(st_q.tag),
        .tpred(tpred), .bpred(bpred[up_pc[LOG_B-1:0]]),
        .hit(up_hit), .prov(up_prov), .pred(up_pred), .alt(up_alt)
    );

    logic [LOG_B-1:0] up_bidx;
    logic             alloc_done;
    assign up_bidx = up_pc[LOG_B-1:0];

    always_comb begin
        st_d       = st_q;
        alloc_done = 1'b0;
        if (up_valid) begin
            if (up_prov == '0) begin
                st_d.bim[up_bidx] = u2_step(st_q.bim[up_bidx], up_taken);
            end else begin
                for (int i = 0; i < N_TAB; i++) begin
                    if (PW'(i + 1) == up_prov) begin
                        st_d.ctr[i][up_idx[i]] = ctr3_step(st_q.ctr[i][up_idx[i]], up_taken);
                        if (up_pred != up_alt)
                            st_d.usef[i][up_idx[i]] =
                                u2_step(st_q.usef[i][up_idx[i]], up_pred == up_taken);
                    end
                end
            end
            if (up_pred != up_taken) begin
                for (int j = 0; j < N_TAB; j++) begin
                    if (PW'(j) >= up_prov && !alloc_done &&
                        st_q.usef[j][up_idx[j]] == 2'd0) begin
                        st_d.vld[j][up_idx[j]]  = 1'b1;
                        st_d.tag[j][up_idx[j]]  = up_tag[j];
                        st_d.ctr[j][up_idx[j]]  = up_taken ? 3'b000 : 3'b111;
                        st_d.usef[j][up_idx[j]] = 2'd0;
                        alloc_done = 1'b1;
                    end
                end
                if (!alloc_done) begin
                    for (int j = 0; j < N_TAB; j++)
                        if (PW'(j) >= up_prov)
                            st_d.usef[j][up_idx[j]] = u2_step(st_q.usef[j][up_idx[j]], 1'b0);
                end
            end
        end
        if (sq_valid) begin
            st_d.ghist = sq_ghist;
            st_d.path  = sq_path;
        end else if (up_valid) begin
            st_d.ghist = {st_q.ghist[HIST_W-2:0], up_taken};
            st_d.path  = {st_q.path[PATH_W-2:0], up_pc[0]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int b = 0; b < BIM_N; b++) st_q.bim[b] <= 2'b01;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: provider is the longest hitting table, none longer hits
    a_r4_longest_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_prov != '0) |-> (((lk_hit >> lk_prov) == '0) && lk_hit[lk_prov - PW'(1)]));

    // R4: with no hit the base table supplies both prediction and alternate
    a_r4_base_default: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit == '0) |-> (lk_prov == '0 && lk_alt == lk_pred));

    // R5: update side applies the same selection rule
    a_r5_update_select: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_hit == '0) |-> (up_prov == '0));

    // R6: base table untouched when a tagged table provided
    a_r6_base_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_prov != '0) |=> $stable(st_q.bim));

    // R10: history shifts in the outcome on an update
    a_r10_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !sq_valid) |=>
        (lk_ghist == {$past(lk_ghist[HIST_W-2:0]), $past(up_taken)}));

    // R10: history holds when idle
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_valid && !sq_valid) |=> ($stable(lk_ghist) && $stable(lk_path)));

    // R11: squash restores both registers
    a_r11_squash: assert property (@(posedge clk) disable iff (!rst_n)
        sq_valid |=> (lk_ghist == $past(sq_ghist) && lk_path == $past(sq_path)));
endmodule

// File: tb/tb_tage_predictor.sv
`timescale 1ns/1ps
module tb_tage_predictor;
    localparam int PC_W = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] lk_pc = '0;
    logic        lk_pred;
    logic [2:0]  lk_prov;
    logic [31:0] lk_ghist;
    logic [4:0]  lk_path;
    logic        up_valid = 1'b0;
    logic [11:0] up_pc = '0;
    logic        up_taken = 1'b0;
    logic [31:0] up_ghist = '0;
    logic [4:0]  up_path = '0;
    logic        sq_valid = 1'b0;
    logic [31:0] sq_ghist = '0;
    logic [4:0]  sq_path = '0;

    always #4 clk = ~clk;

    tage_predictor #(.PC_W(PC_W)) dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_pred(lk_pred),
        .lk_prov(lk_prov), .lk_ghist(lk_ghist), .lk_path(lk_path),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
        .up_ghist(up_ghist), .up_path(up_path), .sq_valid(sq_valid),
        .sq_ghist(sq_ghist), .sq_path(sq_path)
    );

    int n_chk = 0;
    int n_fail = 0;

    // bench model state
    int          m_vld [4][32];
    int          m_tag [4][32];
    int          m_ctr [4][32];
    int          m_u   [4][32];
    int          m_bim [64];
    logic [31:0] m_gh;
    logic [4:0]  m_path;
    int          x_idx [4];
    int          x_tag [4];
    int          x_prov;
    bit          x_pred;
    bit          x_alt;
    string       last_ev = "R1";

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic int foldv(logic [31:0] v, int n, int w);
        int r = 0;
        for (int b = 0; b < n; b++) if (v[b]) r ^= (1 << (b % w));
        return r;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++)
            for (int e = 0; e < 32; e++) begin
                m_vld[i][e] = 0; m_tag[i][e] = 0; m_ctr[i][e] = 0; m_u[i][e] = 0;
            end
        for (int b = 0; b < 64; b++) m_bim[b] = 1;
        m_gh = '0;
        m_path = '0;
    endtask

    // R3 hashing and R4 selection
    task automatic mlook(logic [11:0] pc, logic [31:0] gh, logic [4:0] pa);
        int pi, pt;
        pi = foldv({20'd0, pc}, 12, 5);
        pt = foldv({20'd0, pc} >> 5, 7, 6);
        x_pred = (m_bim[pc[5:0]] >= 2);
        x_alt = x_pred;
        x_prov = 0;
        for (int i = 0; i < 4; i++) begin
            x_idx[i] = pi ^ foldv(gh, 4 << i, 5) ^ int'(pa);
            x_tag[i] = pt ^ foldv(gh, 4 << i, 6);
            if (m_vld[i][x_idx[i]] != 0 && m_tag[i][x_idx[i]] == x_tag[i]) begin
                x_alt = x_pred;
                x_pred = (m_ctr[i][x_idx[i]] >= 0);
                x_prov = i + 1;
            end
        end
    endtask

    task automatic mupdate(logic [11:0] pc, bit tk, logic [31:0] gh, logic [4:0] pa);
        bit found;
        int k, e;
        mlook(pc, gh, pa);
        if (x_prov == 0) begin
            e = int'(pc[5:0]);
            m_bim[e] = tk ? ((m_bim[e] < 3) ? m_bim[e] + 1 : 3) : ((m_bim[e] > 0) ? m_bim[e] - 1 : 0);
            last_ev = "R2";
        end else begin
            k = x_prov - 1;
            e = x_idx[k];
            m_ctr[k][e] = tk ? ((m_ctr[k][e] < 3) ? m_ctr[k][e] + 1 : 3)
                             : ((m_ctr[k][e] > -4) ? m_ctr[k][e] - 1 : -4);
            last_ev = (x_pred == tk) ? "R12" : "R6";
            if (x_pred == tk && x_alt != tk) begin
                if (m_u[k][e] < 3) m_u[k][e]++;
                last_ev = "R7";
            end else if (x_pred != tk && x_alt == tk) begin
                if (m_u[k][e] > 0) m_u[k][e]--;
                last_ev = "R7";
            end
        end
        if (x_pred != tk) begin
            found = 0;
            for (int j = x_prov; j < 4; j++) begin
                if (!found && m_u[j][x_idx[j]] == 0) begin
                    m_vld[j][x_idx[j]] = 1;
                    m_tag[j][x_idx[j]] = x_tag[j];
                    m_ctr[j][x_idx[j]] = tk ? 0 : -1;
                    m_u[j][x_idx[j]] = 0;
                    found = 1;
                    last_ev = "R8";
                end
            end
            if (!found && x_prov < 4) begin
                for (int j = x_prov; j < 4; j++)
                    if (m_u[j][x_idx[j]] > 0) m_u[j][x_idx[j]]--;
                last_ev = "R9";
            end
        end
    endtask

    // one lookup with checks, then the matching update
    task automatic step(logic [11:0] pc, bit tk);
        @(negedge clk);
        up_valid = 1'b0;
        lk_pc = pc;
        #1;
        mlook(pc, m_gh, m_path);
        chk(lk_pred == x_pred, {"R3 R4 pred after ", last_ev}, "lk_pred", int'(lk_pred), int'(x_pred));
        chk(int'(lk_prov) == x_prov, {"R3 R4 provider after ", last_ev}, "lk_prov", int'(lk_prov), x_prov);
        chk(lk_ghist == m_gh, "R5 R10 ghist", "lk_ghist", int'(lk_ghist), int'(m_gh));
        chk(lk_path == m_path, "R5 R10 path", "lk_path", int'(lk_path), int'(m_path));
        up_valid = 1'b1;
        up_pc = pc;
        up_taken = tk;
        up_ghist = lk_ghist;
        up_path = lk_path;
        @(posedge clk);
        mupdate(pc, tk, m_gh, m_path);
        m_gh = {m_gh[30:0], tk};
        m_path = {m_path[3:0], pc[0]};
    endtask

    task automatic squash(logic [31:0] g, logic [4:0] p, bit with_upd, logic [11:0] pc, bit tk);
        @(negedge clk);
        up_valid = with_upd;
        up_pc = pc;
        up_taken = tk;
        up_ghist = m_gh;
        up_path = m_path;
        sq_valid = 1'b1;
        sq_ghist = g;
        sq_path = p;
        @(posedge clk);
        if (with_upd) mupdate(pc, tk, m_gh, m_path);
        m_gh = g;
        m_path = p;
        @(negedge clk);
        sq_valid = 1'b0;
        up_valid = 1'b0;
        #1;
        chk(lk_ghist == g, "R11 squash ghist", "lk_ghist", int'(lk_ghist), int'(g));
        chk(lk_path == p, "R11 squash path", "lk_path", int'(lk_path), int'(p));
    endtask

    initial begin : watchdog
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog req=all act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] lf;
        logic [31:0] save_g;
        logic [4:0]  save_p;
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state over every base index
        for (int p = 0; p < 64; p++) begin
            @(negedge clk);
            lk_pc = 12'(p * 67);
            #1;
            chk(lk_pred == 1'b0, "R1 reset pred", "lk_pred", int'(lk_pred), 0);
            chk(lk_prov == 3'd0, "R1 reset provider", "lk_prov", int'(lk_prov), 0);
        end
        chk(lk_ghist == '0, "R1 reset ghist", "lk_ghist", int'(lk_ghist), 0);
        chk(lk_path == '0, "R1 reset path", "lk_path", int'(lk_path), 0);

        // biased branches: base table saturation and first allocations
        for (int r = 0; r < 40; r++)
            for (int p = 0; p < 16; p++)
                step(12'(p * 37 + 5), (p % 3) != 0);

        // history-correlated branches: tagged tables take over
        for (int s = 0; s < 1500; s++) begin
            logic [11:0] pc;
            pc = 12'((s % 8) * 113 + 9);
            step(pc, m_gh[1] ^ m_gh[3] ^ pc[0]);
        end

        // pseudo-random stream with squashes: aliasing, decay, replacement
        lf = 16'hACE1;
        save_g = m_gh;
        save_p = m_path;
        for (int s = 0; s < 2000; s++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (s % 4 == 0) begin
                save_g = m_gh;
                save_p = m_path;
            end
            step({lf[11:5], 5'(lf[3:0])}, lf[7] ^ (lf[2] & m_gh[0]));
            if (s % 97 == 50) squash(save_g, save_p, 1'b0, '0, 1'b0);
            if (s % 301 == 150) squash(save_g, save_p, 1'b1, lf[11:0], lf[9]);
        end

        // idle cycles hold history (R10)
        @(negedge clk);
        up_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(lk_ghist == m_gh, "R10 idle hold", "lk_ghist", int'(lk_ghist), int'(m_gh));

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule